// File: doc/BRIEF.md
# Processor Status Flags Register

This block keeps the status word of a processor core: six arithmetic condition bits, the interrupt-enable, direction and single-step controls, a two-bit I/O privilege field, a nested-task bit and an alignment-check enable. The core's decode stage drives one-hot operation strobes: set or clear interrupt enable, set or clear direction, read the low byte, write the low byte, push the image and pop an image. The execute stage writes the arithmetic bits through a separate update port. Each operation takes effect on the next rising clock edge.

Changes to interrupt enable are gated by privilege. When the stored I/O privilege level is numerically lower than the current privilege level, a set or clear of interrupt enable raises a one-cycle general-protection fault pulse and leaves the bit unchanged. A pop of a full image applies the same rule to the interrupt-enable bit, and it can change the privilege field only from the most privileged level. The block also gives a one-cycle single-step trap request after each completed instruction while the trap bit is set. It gives a one-cycle alignment fault for a misaligned access while alignment checking is enabled.

Top module: `status_flags_reg`

## Requirements
- R1: After reset, flags_o reads 32'h0000_0002 and gp_fault_o, step_trap_o and align_fault_o are 0.
- R2: op_i bit 0 (set enable) sets flags_o[9] and op_i bit 1 (clear enable) clears it, when the I/O privilege field flags_o[13:12] is greater than or equal to cpl_i.
- R3: op_i bit 2 sets the direction bit flags_o[10] and op_i bit 3 clears it, at any privilege.
- R4: When flags_o[13:12] is less than cpl_i, op_i bit 0 or bit 1 leaves flags_o[9] unchanged and drives gp_fault_o high for exactly the next cycle.
- R5: op_i bit 5 (write low byte) copies data_i bits 7, 6, 4, 2 and 0 into flags_o bits 7, 6, 4, 2 and 0 and changes no other bit. op_i bit 4 (read low byte) and op_i bit 6 (push) change nothing.
- R6: op_i bit 7 (pop) loads every writable bit (0, 2, 4, 6 to 14, 18) from data_i. Bit 9 keeps its value when flags_o[13:12] is less than cpl_i, bits 13:12 keep their value unless cpl_i is 0, and no fault is raised.
- R7: The trap bit flags_o[8] changes only through a pop.
- R8: A pulse on insn_done_i while flags_o[8] is 1 drives step_trap_o high for exactly the next cycle; while flags_o[8] is 0, step_trap_o stays 0.
- R9: A pulse on misalign_i while flags_o[18] is 1 drives align_fault_o high for exactly the next cycle; while flags_o[18] is 0, align_fault_o stays 0.
- R10: alu_we_i writes alu_flags_i bits {5:0} = {OF,SF,ZF,AF,PF,CF} into flags_o bits 11, 7, 6, 4, 2 and 0. A low-byte write or pop in the same cycle takes precedence on the bits it covers.
- R11: flags_o[1] always reads 1, and bits 3, 5, 15 to 17 and 19 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 8 | One-hot operation strobes |
| data_i | input | 32 | Operand for low-byte write and pop |
| alu_we_i | input | 1 | Arithmetic flag update enable |
| alu_flags_i | input | 6 | Arithmetic flag values {OF,SF,ZF,AF,PF,CF} |
| cpl_i | input | 2 | Current privilege level |
| insn_done_i | input | 1 | Instruction completed strobe |
| misalign_i | input | 1 | Misaligned access strobe |
| flags_o | output | 32 | Full flags image |
| gp_fault_o | output | 1 | Protection fault pulse |
| step_trap_o | output | 1 | Single-step trap request |
| align_fault_o | output | 1 | Alignment fault pulse |

## Verification
Some rules are checked by assertions on every cycle. These are the fixed bit 1, the one-hot operation strobes, the stability of the trap bit outside pops, the fault-with-no-change rule for a denied interrupt-enable operation, and the trap and alignment pulses that follow their strobes. Only the bench scenarios can show that whole images come out right after a sequence of operations: which bits a low-byte write touches, how a pop is masked at different privilege levels, and that the arithmetic port and the operation strobes combine as required.

// File: rtl/flags_pkg.sv
package flags_pkg;
  localparam int unsigned NUM_OPS   = 8;
  localparam int unsigned OP_SET_IE = 0;
  localparam int unsigned OP_CLR_IE = 1;
  localparam int unsigned OP_SET_DF = 2;
  localparam int unsigned OP_CLR_DF = 3;
  localparam int unsigned OP_RD_LO  = 4;
  localparam int unsigned OP_WR_LO  = 5;
  localparam int unsigned OP_PUSH   = 6;
  localparam int unsigned OP_POP    = 7;

  localparam int unsigned B_CF = 0;
  localparam int unsigned B_PF = 2;
  localparam int unsigned B_AF = 4;
  localparam int unsigned B_ZF = 6;
  localparam int unsigned B_SF = 7;
  localparam int unsigned B_TF = 8;
  localparam int unsigned B_IE = 9;
  localparam int unsigned B_DF = 10;
  localparam int unsigned B_OF = 11;
  localparam int unsigned B_PL = 12;
  localparam int unsigned PL_W = 2;
  localparam int unsigned B_NT = 14;
  localparam int unsigned B_AC = 18;
  localparam int unsigned B_ONE = 1;
  localparam int unsigned MIN_W = B_AC + 1;
endpackage

// File: rtl/flags_priv_gate.sv
module flags_priv_gate
  import flags_pkg::*;
(
  input  logic [PL_W-1:0] iopl_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic            ie_op_i,
  output logic            ie_ok_o,
  output logic            iopl_ok_o,
  output logic            gp_req_o
);
  always_comb begin
    ie_ok_o   = (iopl_i >= cpl_i);
    iopl_ok_o = (cpl_i == '0);
    gp_req_o  = ie_op_i && !ie_ok_o;
  end
endmodule

// File: rtl/flags_next.sv
module flags_next
  import flags_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic            set_ie_i,
  input  logic            clr_ie_i,
  input  logic            set_df_i,
  input  logic            clr_df_i,
  input  logic            wr_lo_i,
  input  logic            pop_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            alu_we_i,
  input  logic [5:0]      alu_flags_i,
  input  logic            ie_ok_i,
  input  logic            iopl_ok_i,
  output logic [XLEN-1:0] nxt_o
);
  localparam logic [XLEN-1:0] WR_MASK = XLEN'(32'h0004_7FD5);
  localparam logic [XLEN-1:0] LO_MASK = XLEN'(32'h0000_00D5);
  localparam logic [XLEN-1:0] ONE_BIT = XLEN'(1) << B_ONE;
  localparam logic [XLEN-1:0] IE_BIT  = XLEN'(1) << B_IE;
  localparam logic [XLEN-1:0] PL_BITS = XLEN'(3) << B_PL;

  logic [XLEN-1:0] pop_mask;
  logic [XLEN-1:0] w;

  always_comb begin
    pop_mask = WR_MASK;
    if (!ie_ok_i)   pop_mask = pop_mask & ~IE_BIT;
    if (!iopl_ok_i) pop_mask = pop_mask & ~PL_BITS;

    w = cur_i;
    if (alu_we_i) begin
      w[B_CF] = alu_flags_i[0];
      w[B_PF] = alu_flags_i[1];
      w[B_AF] = alu_flags_i[2];
      w[B_ZF] = alu_flags_i[3];
      w[B_SF] = alu_flags_i[4];
      w[B_OF] = alu_flags_i[5];
    end
    if (set_ie_i && ie_ok_i) w[B_IE] = 1'b1;
    if (clr_ie_i && ie_ok_i) w[B_IE] = 1'b0;
    if (set_df_i) w[B_DF] = 1'b1;
    if (clr_df_i) w[B_DF] = 1'b0;
    if (wr_lo_i)  w = (w & ~LO_MASK) | (data_i & LO_MASK);
    if (pop_i)    w = (w & ~pop_mask) | (data_i & pop_mask);
    nxt_o = (w & WR_MASK) | ONE_BIT;
  end
endmodule

// File: rtl/flags_trap_unit.sv
module flags_trap_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tf_i,
  input  logic ac_i,
  input  logic insn_done_i,
  input  logic misalign_i,
  output logic step_trap_o,
  output logic align_fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_trap_o   <= 1'b0;
      align_fault_o <= 1'b0;
    end else begin
      step_trap_o   <= tf_i && insn_done_i;
      align_fault_o <= ac_i && misalign_i;
    end
  end

  AST_STEP_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && tf_i) |=> step_trap_o); // R8
  AST_NO_STEP_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_done_i |=> !step_trap_o); // R8
  AST_ALIGN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misalign_i && ac_i) |=> align_fault_o); // R9
  AST_NO_ALIGN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ac_i |=> !align_fault_o); // R9
endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
  import flags_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OPS-1:0] op_i,
  input  logic [XLEN-1:0]    data_i,
  input  logic               alu_we_i,
  input  logic [5:0]         alu_flags_i,
  input  logic [PL_W-1:0]    cpl_i,
  input  logic               insn_done_i,
  input  logic               misalign_i,
  output logic [XLEN-1:0]    flags_o,
  output logic               gp_fault_o,
  output logic               step_trap_o,
  output logic               align_fault_o
);
  localparam logic [XLEN-1:0] RST_VAL = XLEN'(1) << B_ONE;

  logic [XLEN-1:0] flags_q, flags_d;
  logic            ie_ok, iopl_ok, gp_req;

  flags_priv_gate u_gate (
    .iopl_i   (flags_q[B_PL +: PL_W]),
    .cpl_i    (cpl_i),
    .ie_op_i  (op_i[OP_SET_IE] | op_i[OP_CLR_IE]),
    .ie_ok_o  (ie_ok),
    .iopl_ok_o(iopl_ok),
    .gp_req_o (gp_req)
  );

  flags_next #(.XLEN(XLEN)) u_next (
    .cur_i      (flags_q),
    .set_ie_i   (op_i[OP_SET_IE]),
    .clr_ie_i   (op_i[OP_CLR_IE]),
    .set_df_i   (op_i[OP_SET_DF]),
    .clr_df_i   (op_i[OP_CLR_DF]),
    .wr_lo_i    (op_i[OP_WR_LO]),
    .pop_i      (op_i[OP_POP]),
    .data_i     (data_i),
    .alu_we_i   (alu_we_i),
    .alu_flags_i(alu_flags_i),
    .ie_ok_i    (ie_ok),
    .iopl_ok_i  (iopl_ok),
    .nxt_o      (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= RST_VAL;
      gp_fault_o <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      gp_fault_o <= gp_req;
    end
  end

  flags_trap_unit u_trap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tf_i         (flags_q[B_TF]),
    .ac_i         (flags_q[B_AC]),
    .insn_done_i  (insn_done_i),
    .misalign_i   (misalign_i),
    .step_trap_o  (step_trap_o),
    .align_fault_o(align_fault_o)
  );

  assign flags_o = flags_q;

  // Read-low-byte and push are observational; the image is already on flags_o.
  AST_OPS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_i)); // R5
  AST_BIT1_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[B_ONE]); // R11
  AST_TF_POP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_i[OP_POP] |=> $stable(flags_o[B_TF])); // R7
  AST_DENIED_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i[OP_SET_IE] || op_i[OP_CLR_IE]) && (flags_o[B_PL +: PL_W] < cpl_i))
    |=> (gp_fault_o && $stable(flags_o[B_IE]))); // R4
  AST_POP_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[OP_POP] |=> !gp_fault_o); // R6
  AST_DF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[OP_SET_DF] |=> flags_o[B_DF]); // R3
endmodule

// File: tb/status_flags_reg_bench.sv
module status_flags_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op = '0;
  logic [31:0] data = '0;
  logic        alu_we = 1'b0;
  logic [5:0]  alu_fl = '0;
  logic [1:0]  cpl = '0;
  logic        done = 1'b0;
  logic        mis = 1'b0;
  logic [31:0] flags;
  logic        gp, trap, afault;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  status_flags_reg u_status_flags_reg (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .data_i(data),
    .alu_we_i(alu_we), .alu_flags_i(alu_fl), .cpl_i(cpl),
    .insn_done_i(done), .misalign_i(mis), .flags_o(flags),
    .gp_fault_o(gp), .step_trap_o(trap), .align_fault_o(afault)
  );

  // {op, data, cpl, expected image}; each row sees the state left by the row before
  localparam logic [73:0] VEC [10] = '{
    {8'h01, 32'h0000_0000, 2'd0, 32'h0000_0202},  // R2 set enable
    {8'h04, 32'h0000_0000, 2'd0, 32'h0000_0602},  // R3 set direction
    {8'h20, 32'h0000_00FF, 2'd0, 32'h0000_06D7},  // R5 low-byte write
    {8'h10, 32'h0000_0000, 2'd0, 32'h0000_06D7},  // R5 read low byte
    {8'h08, 32'h0000_0000, 2'd0, 32'h0000_02D7},  // R3 clear direction
    {8'h80, 32'hFFFF_FFFF, 2'd0, 32'h0004_7FD7},  // R6 R11 full pop
    {8'h80, 32'h0000_0000, 2'd3, 32'h0000_3002},  // R6 pop, level kept
    {8'h01, 32'h0000_0000, 2'd3, 32'h0000_3202},  // R2 allowed at cpl 3
    {8'h80, 32'h0000_0000, 2'd0, 32'h0000_0002},  // R6 pop at cpl 0
    {8'h40, 32'h0000_0000, 2'd0, 32'h0000_0002}   // R5 push
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] o, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk);
    op = o; data = d; cpl = c;
    @(negedge clk);
    op = '0; data = '0; alu_we = 1'b0; done = 1'b0; mis = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 image", flags, 32'h0000_0002);
    check("R1 pulses", {29'd0, gp, trap, afault}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][73:66], VEC[i][65:34], VEC[i][33:32]);
      check($sformatf("R2-table row %0d", i), flags, VEC[i][31:0]);
    end

    // R4 denied clear at cpl 1 with level 0
    step(8'h80, 32'h0000_0200, 2'd0);
    check("R6 pop enable", flags, 32'h0000_0202);
    step(8'h02, 32'h0, 2'd1);
    check("R4 enable kept", flags, 32'h0000_0202);
    check("R4 fault pulse", {31'd0, gp}, 32'd1);
    @(negedge clk);
    check("R4 fault one cycle", {31'd0, gp}, 32'd0);

    // R8 single step
    @(negedge clk); done = 1'b1;
    step(8'h00, 32'h0, 2'd0);
    check("R8 no trap when clear", {31'd0, trap}, 32'd0);
    step(8'h80, 32'h0000_0100, 2'd0);
    check("R6 pop trap bit", flags, 32'h0000_0102);
    step(8'h04, 32'h0, 2'd0);
    check("R7 trap bit kept", flags, 32'h0000_0502);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R8 trap pulse", {31'd0, trap}, 32'd1);
    @(negedge clk);
    check("R8 trap one cycle", {31'd0, trap}, 32'd0);

    // R9 alignment
    @(negedge clk); mis = 1'b1;
    @(negedge clk); mis = 1'b0;
    check("R9 no fault when clear", {31'd0, afault}, 32'd0);
    step(8'h80, 32'h0004_0000, 2'd0);
    check("R6 pop align bit", flags, 32'h0004_0002);
    @(negedge clk); mis = 1'b1;
    @(negedge clk); mis = 1'b0;
    check("R9 fault pulse", {31'd0, afault}, 32'd1);
    @(negedge clk);
    check("R9 fault one cycle", {31'd0, afault}, 32'd0);

    // R10 arithmetic port, then with a low-byte write in the same cycle
    @(negedge clk); alu_we = 1'b1; alu_fl = 6'h3F;
    step(8'h00, 32'h0, 2'd0);
    check("R10 alu update", flags, 32'h0004_08D7);
    @(negedge clk); alu_we = 1'b1; alu_fl = 6'h00;
    step(8'h20, 32'h0000_0081, 2'd0);
    check("R10 low-byte write wins", flags, 32'h0004_0083);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule